// File: doc/BRIEF.md
# Four-Channel CRC-64 Signature Engine

This block computes 64-bit cyclic redundancy signatures for software that feeds the data itself. It has four independent channels, and each channel keeps a 64-bit signature register. A CPU reaches every register through a simple single-cycle register bus. Control registers are 32 bits wide. Signature registers are 64 bits wide.

A write to a channel's signature address does one of three things, chosen by that channel's mode field:

- In the full-CPU mode, the 64-bit word is folded into the running CRC-64 in one cycle.
- In the capture mode, the word is copied into the signature unchanged, so software can seed a value or restore one.
- In the two modes that are not implemented, the write is ignored.

Each channel also has a software-reset bit that clears its signature. A global power-down bit freezes all signatures against writes.

The CRC uses the generator x^64 + x^4 + x^3 + x + 1 (constant 0x1B) with no reflection. Bits are taken most-significant first. For each bit, the feedback is the signature's top bit XOR the data bit; the signature shifts left by one and, when the feedback is 1, is XORed with 0x1B. A data word is consumed as eight bytes, starting with its most-significant byte.

Top module: `crc64_sig_engine`

## Requirements
- R1: After the synchronous reset, these registers read 0: the three control registers and all four signatures. The control registers are soft reset at 0x00, power down at 0x08 and mode at 0x10.
- R2: In full-CPU mode (mode code 3), a signature write replaces the signature S with the result of 64 serial steps of the MSB-first rule over data D, taking D's bytes most-significant first.
- R3: In capture mode (mode code 0), a signature write loads the written 64-bit word into the signature unchanged.
- R4: In auto mode (code 1) and semi-CPU mode (code 2), signature writes leave the signature unchanged.
- R5: Channel n's software-reset bit is bit 8*(n-1) of the register at 0x00. While that bit is set, the channel's signature reads 0 and writes to it are ignored. After the bit is cleared, the signature stays 0 until it is written.
- R6: Bit 0 of the register at 0x08 is power down. While it is set, signature writes are ignored and the stored signatures are kept. Once it is cleared, writes take effect again.
- R7: The signatures of channels 1 to 4 sit at 0x60, 0xA0, 0xE0 and 0x120. A write to one channel changes no other channel.
- R8: A read issued in one cycle returns its data on rd_data, with rd_valid high, in the next cycle.
- R8 (readback): Channel n's 2-bit mode field sits at bits [8*(n-1)+1 : 8*(n-1)] of the register at 0x10. Control bits that are not implemented read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 64 | Write data; control registers use bits 31:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data, one cycle after the request |

## Verification
The hardest state to reach from the ports is a signature that is already non-zero when it must be shown to be held. This arises while a channel sits in an ignored mode, during power down, and when a neighbouring channel is reset. The stimulus reaches that state by first seeding each channel through capture mode and only then switching the mode, power-down or reset bit. A frozen register therefore cannot pass simply by reading zero. The full-CPU sequence starts from an all-ones seed and chains eight words, including all-zero and all-ones words, so that every word depends on the previous result.

// File: rtl/crc64_pkg.sv
package crc64_pkg;

    localparam int SIG_W        = 64;
    localparam int CTRL_W       = 32;
    localparam int NUM_CH       = 4;
    localparam int ADDR_W       = 12;
    localparam int FIELD_STRIDE = 8;
    localparam int MODE_W       = 2;

    localparam logic [SIG_W-1:0]  POLY      = 64'h0000_0000_0000_001B;
    localparam logic [ADDR_W-1:0] SWRST_OFS = 12'h000;
    localparam logic [ADDR_W-1:0] PWRDN_OFS = 12'h008;
    localparam logic [ADDR_W-1:0] MODE_OFS  = 12'h010;
    localparam logic [ADDR_W-1:0] SIG_BASE  = 12'h060;
    localparam logic [ADDR_W-1:0] SIG_STEP  = 12'h040;

    typedef enum logic [MODE_W-1:0] {
        MODE_CAPTURE = 2'd0,
        MODE_AUTO    = 2'd1,
        MODE_SEMI    = 2'd2,
        MODE_FULL    = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_FOLD  = 2'd3
    } sig_action_e;

    typedef struct packed {
        logic              swrst;
        logic              pwrdn;
        logic              mode;
        logic [NUM_CH-1:0] sig;
    } addr_hit_t;

    // Byte offset of a channel's signature (channel index zero-based)
    function automatic logic [ADDR_W-1:0] sig_offset(input int idx);
        return SIG_BASE + ADDR_W'(idx) * SIG_STEP;
    endfunction

    // Fold one 64-bit word, MSB first, into the running signature
    function automatic logic [SIG_W-1:0] crc64_fold(input logic [SIG_W-1:0] sig,
                                                    input logic [SIG_W-1:0] data);
        logic [SIG_W-1:0] s;
        logic             fb;
        s = sig;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            fb = s[SIG_W-1] ^ data[i];
            s  = {s[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return s;
    endfunction

    // Priority: software reset, then power down, then mode
    function automatic sig_action_e chan_action(input logic swrst, input logic pwrdn,
                                                input logic wr, input chan_mode_e mode);
        if (swrst)            return ACT_CLEAR;
        if (pwrdn || !wr)     return ACT_HOLD;
        case (mode)
            MODE_CAPTURE:     return ACT_LOAD;
            MODE_FULL:        return ACT_FOLD;
            default:          return ACT_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/crc64_addr_decode.sv
module crc64_addr_decode
    import crc64_pkg::*;
(
    input  logic              access,
    input  logic [ADDR_W-1:0] addr,
    output addr_hit_t         hit
);

    always_comb begin
        hit.swrst = access && (addr == SWRST_OFS);
        hit.pwrdn = access && (addr == PWRDN_OFS);
        hit.mode  = access && (addr == MODE_OFS);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sig_hit
        assign hit.sig[c] = access && (addr == sig_offset(c));
    end

endmodule

// File: rtl/crc64_channel.sv
module crc64_channel
    import crc64_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             swrst,
    input  logic             pwrdn,
    input  chan_mode_e       mode,
    input  logic             wr_en,
    input  logic [SIG_W-1:0] wdata,
    output logic [SIG_W-1:0] sig
);

    sig_action_e      act;
    logic [SIG_W-1:0] folded;

    always_comb begin
        act    = chan_action(swrst, pwrdn, wr_en, mode);
        folded = crc64_fold(sig, wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig <= '0;
        end else begin
            case (act)
                ACT_CLEAR: sig <= '0;
                ACT_LOAD:  sig <= wdata;
                ACT_FOLD:  sig <= folded;
                default:   sig <= sig;
            endcase
        end
    end

    // R5: reset bit forces zero on the next cycle
    assert_swrst_zero_R5: assert property (@(posedge clk) disable iff (rst)
        swrst |=> (sig == '0));

    // R6: power down freezes the signature
    assert_pwrdn_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (pwrdn && !swrst) |=> $stable(sig));

    // R4: unimplemented modes never change the signature
    assert_ignored_mode_R4: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_AUTO || mode == MODE_SEMI) && !swrst) |=> $stable(sig));

    // R7: without a write to this channel, it keeps its value
    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !swrst) |=> $stable(sig));

endmodule

// File: rtl/crc64_sig_engine.sv
module crc64_sig_engine
    import crc64_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIG_W-1:0]  bus_wdata,
    output logic              rd_valid,
    output logic [SIG_W-1:0]  rd_data
);

    addr_hit_t         hit;
    logic              wr_cyc;
    logic              rd_cyc;
    logic [NUM_CH-1:0] swrst_q;
    logic              pwrdn_q;
    chan_mode_e        mode_q [NUM_CH];
    logic [SIG_W-1:0]  sig_w  [NUM_CH];
    logic [CTRL_W-1:0] swrst_rd;
    logic [CTRL_W-1:0] mode_rd;
    logic [SIG_W-1:0]  rd_mux;

    assign wr_cyc = bus_valid && bus_write;
    assign rd_cyc = bus_valid && !bus_write;

    crc64_addr_decode u_decode (
        .access (bus_valid),
        .addr   (bus_addr),
        .hit    (hit)
    );

    // Control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pwrdn_q <= 1'b0;
        end else if (wr_cyc && hit.pwrdn) begin
            pwrdn_q <= bus_wdata[0];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                swrst_q[c] <= 1'b0;
                mode_q[c]  <= MODE_CAPTURE;
            end else begin
                if (wr_cyc && hit.swrst)
                    swrst_q[c] <= bus_wdata[c*FIELD_STRIDE];
                if (wr_cyc && hit.mode)
                    mode_q[c] <= chan_mode_e'(bus_wdata[c*FIELD_STRIDE +: MODE_W]);
            end
        end

        crc64_channel u_chan (
            .clk   (clk),
            .rst   (rst),
            .swrst (swrst_q[c]),
            .pwrdn (pwrdn_q),
            .mode  (mode_q[c]),
            .wr_en (wr_cyc && hit.sig[c]),
            .wdata (bus_wdata),
            .sig   (sig_w[c])
        );
    end

    // Read path
    always_comb begin
        swrst_rd = '0;
        mode_rd  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            swrst_rd[c*FIELD_STRIDE]           = swrst_q[c];
            mode_rd[c*FIELD_STRIDE +: MODE_W]  = mode_q[c];
        end
        rd_mux = '0;
        if (hit.swrst) rd_mux = SIG_W'(swrst_rd);
        if (hit.pwrdn) rd_mux = SIG_W'(pwrdn_q);
        if (hit.mode)  rd_mux = SIG_W'(mode_rd);
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit.sig[c]) rd_mux = sig_w[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_cyc;
            rd_data  <= rd_cyc ? rd_mux : '0;
        end
    end

    // R8: read returns one cycle later
    assert_rd_latency_R8: assert property (@(posedge clk) disable iff (rst)
        rd_cyc |=> rd_valid);

    assert_rd_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_cyc |=> !rd_valid);

    // R7: at most one register selected per access
    assert_onehot_hit_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit.swrst, hit.pwrdn, hit.mode, hit.sig}));

    // R1: reset clears control state
    assert_reset_ctrl_R1: assert property (@(posedge clk)
        rst |=> (swrst_q == '0 && !pwrdn_q && !rd_valid));

endmodule

// File: tb/crc64_sig_engine_tb_top.sv
module crc64_sig_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    crc64_sig_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    localparam logic [11:0] A_SWRST = 12'h000;
    localparam logic [11:0] A_PWRDN = 12'h008;
    localparam logic [11:0] A_MODE  = 12'h010;
    localparam logic [11:0] A_SIG [4] = '{12'h060, 12'h0A0, 12'h0E0, 12'h120};

    localparam int NVEC = 8;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001,
        64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0080,
        64'hA5A5_5A5A_0F0F_F0F0, 64'h1122_3344_5566_7788
    };

    // Byte-wise reference, most-significant byte first
    function automatic logic [63:0] ref_fold(logic [63:0] s, logic [63:0] d);
        for (int b = 0; b < 8; b++) begin
            logic [7:0] byt;
            byt = d[63 - 8*b -: 8];
            for (int j = 0; j < 8; j++) begin
                logic top;
                top = s[63];
                s   = s << 1;
                if ((byt & (8'h80 >> j)) != 0) top = ~top;
                if (top) s = s ^ 64'h1B;
            end
        end
        return s;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
        logic [63:0] d;
        logic        v;
        rd(a, d, v);
        chk({req, " rd_valid"}, {63'd0, v}, 64'd1);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] exp1;
        logic [63:0] exp2;
        logic [63:0] exp4;
        logic [63:0] d;
        logic        v;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk("R1 swrst", A_SWRST, 64'h0);
        rd_chk("R1 pwrdn", A_PWRDN, 64'h0);
        rd_chk("R1 mode", A_MODE, 64'h0);
        for (int c = 0; c < 4; c++) rd_chk("R1 sig", A_SIG[c], 64'h0);

        // R3: capture seed into channel 1
        wr(A_SIG[0], 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R3 seed", A_SIG[0], 64'hFFFF_FFFF_FFFF_FFFF);
        exp1 = 64'hFFFF_FFFF_FFFF_FFFF;

        // R2: channel 1 to full-CPU, walk the vector table
        wr(A_MODE, 64'h0000_0003);
        rd_chk("R8 mode readback", A_MODE, 64'h0000_0003);
        for (int i = 0; i < NVEC; i++) begin
            exp1 = ref_fold(exp1, VEC[i]);
            wr(A_SIG[0], VEC[i]);
            rd_chk("R2 fold", A_SIG[0], exp1);
        end

        // R3/R7: capture into channel 2, channel 1 untouched
        wr(A_SIG[1], 64'h0BAD_F00D_1234_5678);
        exp2 = 64'h0BAD_F00D_1234_5678;
        rd_chk("R3 capture ch2", A_SIG[1], exp2);
        rd_chk("R7 ch1 kept", A_SIG[0], exp1);

        // R7: channel 4 at 0x120, capture then fold
        wr(A_SIG[3], 64'h0000_0000_0000_0001);
        wr(A_MODE, 64'h0300_0003);
        wr(A_SIG[3], 64'hCAFE_0000_0000_BABE);
        exp4 = ref_fold(64'h1, 64'hCAFE_0000_0000_BABE);
        rd_chk("R7 ch4 fold", A_SIG[3], exp4);
        rd_chk("R7 ch2 kept", A_SIG[1], exp2);

        // R4: channel 3 seeded, then auto and semi modes ignore writes
        wr(A_SIG[2], 64'h5555_AAAA_5555_AAAA);
        wr(A_MODE, 64'h0301_0003);
        wr(A_SIG[2], 64'h1234_0000_0000_4321);
        rd_chk("R4 auto ignored", A_SIG[2], 64'h5555_AAAA_5555_AAAA);
        wr(A_MODE, 64'h0302_0003);
        wr(A_SIG[2], 64'h9999_0000_0000_9999);
        rd_chk("R4 semi ignored", A_SIG[2], 64'h5555_AAAA_5555_AAAA);

        // R6: power down freezes writes
        wr(A_PWRDN, 64'h1);
        rd_chk("R6 pwrdn readback", A_PWRDN, 64'h1);
        wr(A_SIG[1], 64'hFEED_FEED_FEED_FEED);
        wr(A_SIG[0], 64'h7777_7777_7777_7777);
        rd_chk("R6 ch2 frozen", A_SIG[1], exp2);
        rd_chk("R6 ch1 frozen", A_SIG[0], exp1);
        wr(A_PWRDN, 64'h0);
        wr(A_SIG[0], 64'h7777_7777_7777_7777);
        exp1 = ref_fold(exp1, 64'h7777_7777_7777_7777);
        rd_chk("R6 resumed", A_SIG[0], exp1);

        // R5: software reset of channel 1 (bit 0)
        wr(A_SWRST, 64'h0000_0001);
        rd_chk("R5 swrst readback", A_SWRST, 64'h0000_0001);
        rd_chk("R5 cleared", A_SIG[0], 64'h0);
        wr(A_SIG[0], 64'h1357_9BDF_2468_ACE0);
        rd_chk("R5 write ignored", A_SIG[0], 64'h0);
        rd_chk("R7 ch2 not reset", A_SIG[1], exp2);
        wr(A_SWRST, 64'h0);
        rd_chk("R5 stays zero", A_SIG[0], 64'h0);
        wr(A_SIG[0], 64'h1357_9BDF_2468_ACE0);
        rd_chk("R5 fold after release", A_SIG[0], ref_fold(64'h0, 64'h1357_9BDF_2468_ACE0));

        // R5: channel 4 reset bit is bit 24
        wr(A_SWRST, 64'h0100_0000);
        rd_chk("R5 ch4 cleared", A_SIG[3], 64'h0);
        rd_chk("R5 ch3 kept", A_SIG[2], 64'h5555_AAAA_5555_AAAA);
        wr(A_SWRST, 64'h0);

        // R8: readback masks and unmapped address
        wr(A_MODE, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R8 mode mask", A_MODE, 64'h0303_0303);
        wr(A_PWRDN, 64'hFFFF_FFFE);
        rd_chk("R8 pwrdn mask", A_PWRDN, 64'h0);
        rd_chk("R8 unmapped", 12'h0C0, 64'h0);

        // R8: no read -> rd_valid low
        @(negedge clk);
        chk("R8 idle rd_valid", {63'd0, rd_valid}, 64'd0);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(A_SIG[1], d, v);
        chk("R1 sig after reset", d, 64'h0);
        rd_chk("R1 mode after reset", A_MODE, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule